// File: doc/BRIEF.md
# Priority Interrupt Controller with Fast-Interrupt Routing

This block gathers interrupt lines from 32 sources and turns them into requests for a processor core. Each source is either level-sensitive or rising-edge-sensitive, fixed at build time. Each source has an enable bit, and its 4-bit priority comes from one of 16 priority registers. A build-time map says which priority register each source uses, so several sources can share one.

The controller keeps at most one request outstanding. A request is a 12-bit word with the priority in the upper nibble and the source number in the lower byte. When no request is outstanding, an enabled event on a source starts a request at once. When the core acknowledges, the controller retires the request and runs a combinational search over the pending sources. The winner is issued on the same clock edge, so it is visible in the cycle after the acknowledge.

One programmable vector can be steered to a separate fast-interrupt output. A register write can pulse a software-interrupt line. Software reaches all state through a small bus. Each register has a single legal access width.

Top module: `prio_intc`

## Requirements
- R1: After reset, both request words are 0, `swi_pulse` is 0, and every enable, priority and fast-routing register reads 0.
- R2: A new event starts a request only when:
  - no request is outstanding,
  - the source's enable bit is 1, and
  - the source number is not 0.

  If several sources qualify on the same edge, the lowest-numbered one is taken. A source that is refused stays pending.
- R3: The request word is {priority[3:0], source number[7:0]}. The priority is the value of the source's mapped priority register when the request is issued.
- R4: The fast-routing register is 16 bits at address 0x70. Bit 15 enables routing and bits 7:0 hold the vector. While bit 15 is 1 and the vector equals the outstanding source number, the word appears on `fiq_word` and `irq_word` reads 0. Otherwise the reverse holds. Both are never nonzero together.
- R5: When `ack` is sampled high with a request outstanding:
  - the request is retired, and an edge-mode owner has its pending flag cleared;
  - among the pending sources, the one with the strictly highest nonzero priority is chosen, with ties going to the lowest source number;
  - the chosen source is issued on that same edge only if it is enabled and is not source 0. Otherwise no request is outstanding and the chosen source stays pending.
- R6: When the line of a level-mode source that owns the outstanding request goes low, the request is withdrawn and both request words read 0 after the next edge.
- R7: The enable register bytes are at 0x20 + n/8. Bit n%8 of that byte enables source n.
- R8: A byte write with bit 0 set to address 0x60 makes `swi_pulse` high for exactly one cycle. A write with bit 0 clear makes no pulse. Address 0x60 always reads 0.
- R9: Address 0x70 accepts only 16-bit accesses (`bus_size`=1). Every other address accepts only 8-bit accesses (`bus_size`=0). A write of the wrong size changes nothing, and a read of the wrong size returns 0xFFFF.
- R10: The priority registers are at 0x40 + p and hold 4 bits. Bits 7:4 read as 0. With the default map, source n uses register n/2, so sources 2k and 2k+1 share a priority.
- R11: The pending flags read at address n, in bit 0.
  - An edge-mode source becomes pending on a rising edge of its line.
  - A level-mode source's pending flag follows its line, one edge late.
  - Sources 4 to 7 are level mode by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_line | input | 32 | Interrupt lines, one per source |
| ack | input | 1 | Core acknowledges the outstanding request |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 1 | Access width: 0 = 8-bit, 1 = 16-bit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address and size |
| irq_word | output | 12 | Normal request {priority, vector}, 0 when idle |
| fiq_word | output | 12 | Fast-routed request {priority, vector}, 0 when idle |
| swi_pulse | output | 1 | One-cycle software-interrupt pulse |

## Verification
The hardest case to reach is arbitration after an acknowledge. It needs several sources pending at once while a request is outstanding, including:
- ties on a shared priority register,
- zero priorities, and
- a winner that is disabled or is source 0.

The stimulus holds one request outstanding on purpose, then raises several edge lines in the same cycle so that they pile up as pending. It then acknowledges repeatedly until the controller goes idle. Random priorities and random source sets drive this loop, and a model rebuilt from bus reads of the pending flags predicts each word. Directed cases cover a disabled winner and the level-source re-issue after an acknowledge.

// File: rtl/prio_intc_pkg.sv
// Shared constants for the priority interrupt controller.
// Assumes an 8-bit register address space and 4-bit priorities.
package prio_intc_pkg;
    localparam int PRI_W = 4;
    localparam int VEC_W = 8;
    localparam int WORD_W = PRI_W + VEC_W;

    localparam logic [7:0] A_PEND = 8'h00;
    localparam logic [7:0] A_EN   = 8'h20;
    localparam logic [7:0] A_PRI  = 8'h40;
    localparam logic [7:0] A_SWI  = 8'h60;
    localparam logic [7:0] A_FAST = 8'h70;

    typedef struct packed {
        logic             valid;
        logic [PRI_W-1:0] pri;
        logic [VEC_W-1:0] vec;
    } req_t;
endpackage

// File: rtl/prio_intc_src.sv
// Per-source trigger logic: holds the pending flags and flags new events.
// Assumes LEVEL_MASK is fixed at build time. A level source follows its
// line and ignores clears; an edge source latches rising edges.
module prio_intc_src #(
    parameter int NUM_SRC = 32,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_line,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] event_vec
);
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        if (LEVEL_MASK[n]) begin : g_level
            logic unused_clr;
            assign unused_clr   = clr_vec[n];
            assign event_vec[n] = src_line[n];
            // Pending mirrors the line one edge late.
            always_ff @(posedge clk) begin
                if (!rst_n) pend[n] <= 1'b0;
                else        pend[n] <= src_line[n];
            end
        end else begin : g_edge
            logic prev_q;
            assign event_vec[n] = src_line[n] & ~prev_q;
            // Remember the line and latch rising edges; a new edge beats a clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q  <= 1'b0;
                    pend[n] <= 1'b0;
                end else begin
                    prev_q  <= src_line[n];
                    pend[n] <= (pend[n] & ~clr_vec[n]) | event_vec[n];
                end
            end
        end
    end
endmodule

// File: rtl/prio_intc_tree.sv
// Combinational binary tree that picks the candidate with the strictly
// highest nonzero priority, with ties going to the lower index.
// Assumes NUM_SRC is a power of two.
module prio_intc_tree
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]       cand,
    input  logic [NUM_SRC*PRI_W-1:0] src_pri,
    output logic                     win_valid,
    output logic [IDX_W-1:0]         win_idx,
    output logic [PRI_W-1:0]         win_pri
);
    logic             nv [1:2*NUM_SRC-1];
    logic [PRI_W-1:0] np [1:2*NUM_SRC-1];
    logic [IDX_W-1:0] ni [1:2*NUM_SRC-1];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_leaf
        assign nv[NUM_SRC+i] = cand[i] && (src_pri[i*PRI_W +: PRI_W] != '0);
        assign np[NUM_SRC+i] = src_pri[i*PRI_W +: PRI_W];
        assign ni[NUM_SRC+i] = IDX_W'(i);
    end

    for (genvar j = 1; j < NUM_SRC; j++) begin : g_node
        logic take_r;
        // The right child wins only if it is valid and strictly higher.
        assign take_r = nv[2*j+1] && (!nv[2*j] || (np[2*j+1] > np[2*j]));
        assign nv[j]  = nv[2*j] || nv[2*j+1];
        assign np[j]  = take_r ? np[2*j+1] : np[2*j];
        assign ni[j]  = take_r ? ni[2*j+1] : ni[2*j];
    end

    assign win_valid = nv[1];
    assign win_idx   = ni[1];
    assign win_pri   = np[1];

    // R5: the winner is at least as high as every valid candidate.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && src_pri[i*PRI_W +: PRI_W] != '0)
                a_r5_tree_max: assert (win_valid && win_pri >= src_pri[i*PRI_W +: PRI_W]);
        end
    end
endmodule

// File: rtl/prio_intc_regs.sv
// Register bank: enable bytes, priority registers, fast-routing register,
// software-interrupt strobe and a read-only view of the pending flags.
// Assumes NUM_SRC >= 16 and that the bases are aligned to their extents.
module prio_intc_regs
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_PRI = 16,
    localparam int IDX_W = $clog2(NUM_SRC),
    localparam int EN_BYTES = NUM_SRC / 8,
    localparam int EN_IW = $clog2(EN_BYTES),
    localparam int MAP_W = $clog2(NUM_PRI)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_size,
    input  logic [15:0]              bus_wdata,
    output logic [15:0]              bus_rdata,
    input  logic [NUM_SRC-1:0]       pend,
    output logic [NUM_SRC-1:0]       en_vec,
    output logic [NUM_PRI*PRI_W-1:0] pri_flat,
    output logic                     fast_en,
    output logic [VEC_W-1:0]         fast_vec,
    output logic                     swi_pulse
);
    localparam logic [7:0] PEND_END = A_PEND + 8'(NUM_SRC);
    localparam logic [7:0] EN_END   = A_EN + 8'(EN_BYTES);
    localparam logic [7:0] PRI_END  = A_PRI + 8'(NUM_PRI);

    logic [7:0]       en_q  [EN_BYTES];
    logic [PRI_W-1:0] pri_q [NUM_PRI];
    logic             fast_en_q;
    logic [VEC_W-1:0] fast_vec_q;
    logic             swi_q;
    logic is_pend, is_en, is_pri, is_swi, is_fast, size_ok;
    logic unused_wbits;

    assign unused_wbits = ^bus_wdata[14:8];

    // Address decode and access-width check.
    always_comb begin
        is_pend = bus_addr < PEND_END;
        is_en   = bus_addr >= A_EN && bus_addr < EN_END;
        is_pri  = bus_addr >= A_PRI && bus_addr < PRI_END;
        is_swi  = bus_addr == A_SWI;
        is_fast = bus_addr == A_FAST;
        size_ok = is_fast ? bus_size : !bus_size;
    end

    // Register writes; the software strobe lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < EN_BYTES; b++) en_q[b] <= '0;
            for (int p = 0; p < NUM_PRI; p++) pri_q[p] <= '0;
            fast_en_q  <= 1'b0;
            fast_vec_q <= '0;
            swi_q      <= 1'b0;
        end else begin
            swi_q <= 1'b0;
            if (bus_wr && size_ok) begin
                if (is_en)   en_q[bus_addr[EN_IW-1:0]]  <= bus_wdata[7:0];
                if (is_pri)  pri_q[bus_addr[MAP_W-1:0]] <= bus_wdata[PRI_W-1:0];
                if (is_fast) begin
                    fast_en_q  <= bus_wdata[15];
                    fast_vec_q <= bus_wdata[VEC_W-1:0];
                end
                if (is_swi)  swi_q <= bus_wdata[0];
            end
        end
    end

    // Read mux; a wrong width or an unmapped address returns all ones.
    always_comb begin
        bus_rdata = '1;
        if (size_ok) begin
            if (is_pend)      bus_rdata = {15'd0, pend[bus_addr[IDX_W-1:0]]};
            else if (is_en)   bus_rdata = {8'd0, en_q[bus_addr[EN_IW-1:0]]};
            else if (is_pri)  bus_rdata = {12'd0, pri_q[bus_addr[MAP_W-1:0]]};
            else if (is_swi)  bus_rdata = 16'd0;
            else if (is_fast) bus_rdata = {fast_en_q, 7'd0, fast_vec_q};
        end
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_en
        assign en_vec[n] = en_q[n/8][n%8];
    end
    for (genvar p = 0; p < NUM_PRI; p++) begin : g_pri
        assign pri_flat[p*PRI_W +: PRI_W] = pri_q[p];
    end
    assign fast_en   = fast_en_q;
    assign fast_vec  = fast_vec_q;
    assign swi_pulse = swi_q;

    // R9: a byte-wide write to the fast register leaves it untouched.
    a_r9_fast_size: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_fast && !bus_size) |=> ($stable(fast_en_q) && $stable(fast_vec_q)));
    // R8: a pulse is never followed by another unless a new write came in.
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (swi_q && !(bus_wr && is_swi)) |=> !swi_q);
endmodule

// File: rtl/prio_intc.sv
// Top of the priority interrupt controller. Holds the single outstanding
// request, starts it from new events, re-arbitrates on acknowledge,
// withdraws it when its level source drops, and routes it to the normal
// or the fast output.
// Assumes PRI_MAP entries are below NUM_PRI.
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_PRI = 16,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 32'h0000_00F0,
    parameter logic [NUM_SRC*$clog2(NUM_PRI)-1:0] PRI_MAP =
        128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_line,
    input  logic               ack,
    input  logic [7:0]         bus_addr,
    input  logic               bus_wr,
    input  logic               bus_size,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    output logic [WORD_W-1:0]  irq_word,
    output logic [WORD_W-1:0]  fiq_word,
    output logic               swi_pulse
);
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int MAP_W = $clog2(NUM_PRI);

    logic [NUM_SRC-1:0]       pend, event_vec, en_vec, clr_vec, cand;
    logic [NUM_PRI*PRI_W-1:0] pri_flat;
    logic [NUM_SRC*PRI_W-1:0] src_pri;
    logic                     fast_en;
    logic [VEC_W-1:0]         fast_vec;
    logic                     win_valid, ev_found, withdraw, to_fast, owner_lvl;
    logic [IDX_W-1:0]         win_idx, ev_idx;
    logic [PRI_W-1:0]         win_pri;
    logic                     req_valid;
    logic [IDX_W-1:0]         req_src;
    logic [PRI_W-1:0]         req_pri;

    prio_intc_regs #(.NUM_SRC(NUM_SRC), .NUM_PRI(NUM_PRI)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend(pend), .en_vec(en_vec), .pri_flat(pri_flat), .fast_en(fast_en),
        .fast_vec(fast_vec), .swi_pulse(swi_pulse));

    prio_intc_src #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) i_src (
        .clk(clk), .rst_n(rst_n), .src_line(src_line), .clr_vec(clr_vec),
        .pend(pend), .event_vec(event_vec));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_map
        localparam int P = int'(PRI_MAP[i*MAP_W +: MAP_W]);
        assign src_pri[i*PRI_W +: PRI_W] = pri_flat[P*PRI_W +: PRI_W];
    end

    prio_intc_tree #(.NUM_SRC(NUM_SRC)) i_tree (
        .cand(cand), .src_pri(src_pri), .win_valid(win_valid),
        .win_idx(win_idx), .win_pri(win_pri));

    // Retirement clear for an edge owner, and the candidates left after it.
    always_comb begin
        owner_lvl = LEVEL_MASK[req_src];
        clr_vec   = (ack && req_valid && !owner_lvl) ? (NUM_SRC'(1) << req_src) : '0;
        cand      = pend & ~clr_vec;
        withdraw  = req_valid && owner_lvl && !src_line[req_src];
    end

    // Lowest-numbered enabled new event, excluding source 0.
    always_comb begin
        ev_found = 1'b0;
        ev_idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (i != 0 && event_vec[i] && en_vec[i]) begin
                ev_found = 1'b1;
                ev_idx   = IDX_W'(i);
            end
        end
    end

    // Outstanding request: re-arbitrate on ack, withdraw, or start from an event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_src   <= '0;
            req_pri   <= '0;
        end else if (ack && req_valid) begin
            req_valid <= win_valid && en_vec[win_idx] && (win_idx != '0);
            req_src   <= win_idx;
            req_pri   <= win_pri;
        end else if (withdraw) begin
            req_valid <= 1'b0;
        end else if (!req_valid && ev_found) begin
            req_valid <= 1'b1;
            req_src   <= ev_idx;
            req_pri   <= src_pri[ev_idx*PRI_W +: PRI_W];
        end
    end

    // Output routing toward the normal or the fast line.
    always_comb begin
        to_fast  = fast_en && (fast_vec == VEC_W'(req_src));
        irq_word = (req_valid && !to_fast) ? {req_pri, VEC_W'(req_src)} : '0;
        fiq_word = (req_valid && to_fast)  ? {req_pri, VEC_W'(req_src)} : '0;
    end

    // R4: the two outputs are never active together.
    a_r4_one_output: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_word != '0 && fiq_word != '0));
    // R6: a dropped level owner leaves no request after the next edge.
    a_r6_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        (withdraw && !ack) |=> !req_valid);
    // R2: an idle controller with an eligible event issues on the next edge.
    a_r2_idle_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && ev_found) |=> req_valid);
    // R5: without ack or withdrawal the outstanding request holds.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ack && !withdraw) |=> (req_valid && $stable(req_src) && $stable(req_pri)));
endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_line = '0;
    logic        ack = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_size = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [11:0] irq_word, fiq_word;
    logic        swi_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0]  pri_m [16];
    logic [31:0] pend_m;

    always #5 clk = ~clk;

    prio_intc i_prio_intc (
        .clk(clk), .rst_n(rst_n), .src_line(src_line), .ack(ack),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_word(irq_word),
        .fiq_word(fiq_word), .swi_pulse(swi_pulse));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic sz);
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic sz, output logic [15:0] d);
        bus_addr = a; bus_size = sz;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] lines);
        src_line = lines;
        tick();
        src_line = '0;
        tick();
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    function automatic logic [11:0] word(input logic [3:0] p, input int n);
        return {p, 8'(n)};
    endfunction

    // Expected word after an ack, from the requirement rule in R5 (all enabled).
    function automatic logic [11:0] best_word(input logic [31:0] pend);
        int b = -1;
        logic [3:0] bp = 0;
        for (int i = 0; i < 32; i++)
            if (pend[i] && pri_m[i >> 1] > bp) begin b = i; bp = pri_m[i >> 1]; end
        if (b <= 0) return 12'h000;
        return word(bp, b);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL all: watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [31:0] s;
        logic [11:0] e;
        int cur;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 irq_word", irq_word, 0);
        chk("R1 fiq_word", fiq_word, 0);
        chk("R1 swi_pulse", swi_pulse, 0);
        rd(8'h21, 0, d); chk("R1 enable", d, 0);
        rd(8'h45, 0, d); chk("R1 priority", d, 0);
        rd(8'h70, 1, d); chk("R1 fast", d, 0);

        // R10: 4-bit priority register
        wr(8'h44, 16'h003A, 0);
        rd(8'h44, 0, d); chk("R10 upper bits zero", d, 16'h000A);

        // R7: only the enabled bit of byte 1 lets source 9 through
        wr(8'h21, 16'h0002, 0);
        pulse(32'h1 << 10);
        chk("R7 disabled source 10", irq_word, 0);
        pulse(32'h1 << 9);
        chk("R3 word for source 9", irq_word, word(4'hA, 9));

        // R2: a second event while outstanding does not replace the request
        wr(8'h21, 16'h0003, 0);
        pulse(32'h1 << 8);
        chk("R2 outstanding kept", irq_word, word(4'hA, 9));
        rd(8'h08, 0, d); chk("R11 edge pending 8", d, 1);

        // R4: fast routing on match
        wr(8'h70, 16'h8009, 1);
        chk("R4 normal off", irq_word, 0);
        chk("R4 fast on", fiq_word, word(4'hA, 9));
        // R9: wrong widths ignored, read all ones
        wr(8'h70, 16'h0000, 0);
        chk("R9 byte write fast ignored", fiq_word, word(4'hA, 9));
        rd(8'h70, 1, d); chk("R9 fast readback", d, 16'h8009);
        rd(8'h70, 0, d); chk("R9 byte read fast", d, 16'hFFFF);
        rd(8'h21, 1, d); chk("R9 halfword read enable", d, 16'hFFFF);
        wr(8'h21, 16'h0000, 1);
        rd(8'h21, 0, d); chk("R9 halfword write enable ignored", d, 16'h0003);
        wr(8'h70, 16'h0009, 1);
        chk("R4 fast disabled", fiq_word, 0);
        chk("R4 normal back", irq_word, word(4'hA, 9));

        // R8: software pulse
        wr(8'h60, 16'h0001, 0);
        chk("R8 pulse high", swi_pulse, 1);
        tick();
        chk("R8 pulse one cycle", swi_pulse, 0);
        wr(8'h60, 16'h0002, 0);
        chk("R8 bit0 clear no pulse", swi_pulse, 0);
        rd(8'h60, 0, d); chk("R8 reads zero", d, 0);

        // R5: ack re-arbitrates; priority 0 (source 10) never chosen
        do_ack();
        chk("R5 next is source 8", irq_word, word(4'hA, 8));
        rd(8'h09, 0, d); chk("R5 acked edge source cleared", d, 0);
        do_ack();
        chk("R5 zero priority not chosen", irq_word, 0);
        rd(8'h0A, 0, d); chk("R5 source 10 still pending", d, 1);
        // R5 tie on a shared register: lower number wins
        wr(8'h21, 16'h0013, 0);
        wr(8'h46, 16'h0003, 0);
        pulse(32'h1 << 12);
        chk("R3 word for source 12", irq_word, word(4'h3, 12));
        pulse((32'h1 << 9) | (32'h1 << 8));
        do_ack();
        chk("R5 tie lowest number", irq_word, word(4'hA, 8));
        do_ack();
        chk("R5 tie second", irq_word, word(4'hA, 9));
        do_ack();
        chk("R5 drained", irq_word, 0);

        // R2: source 0 never requested
        wr(8'h20, 16'h0001, 0);
        pulse(32'h1);
        chk("R2 source 0 refused", irq_word, 0);
        rd(8'h00, 0, d); chk("R2 source 0 pending", d, 1);

        // R5: disabled winner stays pending, no request
        pulse(32'h1 << 9);
        wr(8'h47, 16'h0009, 0);
        pulse((32'h1 << 14) | (32'h1 << 12));
        do_ack();
        chk("R5 disabled winner not issued", irq_word, 0);
        rd(8'h0E, 0, d); chk("R5 disabled winner pending", d, 1);
        pulse(32'h1 << 9);
        chk("R2 new event after refusal", irq_word, word(4'hA, 9));
        wr(8'h21, 16'h0053, 0);
        do_ack();
        chk("R5 enabled winner issued", irq_word, word(4'h9, 14));
        do_ack();
        chk("R5 next lower priority", irq_word, word(4'h3, 12));
        do_ack();
        chk("R5 idle again", irq_word, 0);

        // R6 / R11: level source 5
        wr(8'h20, 16'h0021, 0);
        wr(8'h42, 16'h0007, 0);
        src_line[5] = 1'b1;
        tick();
        chk("R11 level issues", irq_word, word(4'h7, 5));
        rd(8'h05, 0, d); chk("R11 level pending follows", d, 1);
        do_ack();
        chk("R5 level still high reissued", irq_word, word(4'h7, 5));
        src_line[5] = 1'b0;
        tick();
        chk("R6 withdrawn", irq_word, 0);
        chk("R6 fast also 0", fiq_word, 0);
        rd(8'h05, 0, d); chk("R11 level pending drops", d, 0);

        // Random arbitration rounds
        for (int b = 0; b < 4; b++) wr(8'(8'h20 + b), 16'h00FF, 0);
        for (int p = 0; p < 16; p++) begin
            pri_m[p] = 4'($urandom % 16);
            wr(8'(8'h40 + p), {12'd0, pri_m[p]}, 0);
        end
        pend_m = '0;
        for (int i = 0; i < 32; i++) begin
            rd(8'(i), 0, d);
            pend_m[i] = d[0];
        end
        for (int it = 0; it < 40; it++) begin
            pulse(32'h2);
            pend_m[1] = 1'b1;
            chk("R2 random idle issue", irq_word, word(pri_m[0], 1));
            cur = 1;
            s = $urandom & 32'hFFFF_FF0C;
            pulse(s);
            pend_m |= s;
            for (int k = 0; k < 34; k++) begin
                do_ack();
                pend_m[cur] = 1'b0;
                e = best_word(pend_m);
                chk("R5 random re-arbitration", irq_word, e);
                if (e == 0) break;
                cur = int'(e[7:0]);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule